// File: doc/BRIEF.md
# Carrier-Period Interrupt Decimation Counter

This block thins a stream of PWM carrier events down to one interrupt request every n events, so that software servicing a motor-control loop is woken only once per chosen number of carrier periods. A counting event is either a carrier-timer underflow strobe or an edge of the reload-control signal from a companion one-shot timer. Which one counts depends on a mode bit, a source-select bit and a polarity bit.

In the basic mode only the carrier underflow counts, and the select and polarity bits have no effect. In the extended mode the source-select bit picks the underflow or an edge of the reload-control signal, and the polarity bit picks which edge. After the block is armed, the first period is one event shorter than n. Every later period is n events long. Arming happens at reset, on every write of a new reload value, and while the master enable is low.

Top module: `carrier_irq_decimator`

## Requirements
- R1: When `ext_mode` is 0 and `mode_en` is 1, every clock cycle with `carrier_uf` high is one counting event. `src_sel`, `edge_pol` and `reload_ctl` have no effect on the count.
- R2: When `ext_mode` is 1 and `src_sel` is 0, every clock cycle with `carrier_uf` high is one counting event, and `reload_ctl` is ignored.
- R3: When `ext_mode` is 1 and `src_sel` is 1, the counting event is a change of `reload_ctl` between two consecutive clock samples. With `edge_pol` 0 the event is a change from 0 to 1; with `edge_pol` 1 it is a change from 1 to 0. `carrier_uf` is ignored.
- R4: After arming, the first interrupt follows the max(n-1,1)-th counting event.
- R5: After the first interrupt, an interrupt follows every n-th counting event.
- R6: A stored reload value of 0 behaves exactly like a value of 1.
- R7: For each completed period, `irq` is high for exactly one clock cycle: the cycle after the clock edge that sampled the completing event.
- R8: While `mode_en` is 0, no event is counted and `irq` stays 0. The counter is also re-armed, so when `mode_en` returns to 1 a fresh first period starts.
- R9: A cycle with `reload_wr` high stores `reload_data` and re-arms the counter into its first period. If a counting event arrives in the same cycle, the re-arm wins and the event is discarded.
- R10: After reset, `irq` is 0, the stored reload value is 0 and the counter is armed in its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_en | input | 1 | Master enable of the counter |
| ext_mode | input | 1 | 0 = basic mode, 1 = extended mode |
| src_sel | input | 1 | Extended-mode source: 0 = carrier underflow, 1 = reload-control edge |
| edge_pol | input | 1 | Edge choice for the reload-control source: 0 = rising, 1 = falling |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_data | input | CNT_W | Reload value n |
| carrier_uf | input | 1 | Carrier-timer underflow strobe |
| reload_ctl | input | 1 | Reload-control level from the one-shot timer |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The hardest situation to reach from the ports is the boundary between the short first period and the full-length periods that follow. The bench also has to show that the source not selected leaves the count untouched. Each table vector therefore re-arms the block and then drives a chosen number of events on the selected source, with distracting pulses on the other source between them. The bench compares the total interrupt count against a closed-form count built from the first-period and steady-period lengths. Directed tests then re-arm the block part way through a period, both by a reload write and by dropping the enable. They also place a reload write in the same cycle as an event, which shows that the partial count is lost.

// File: rtl/cpid_pkg.sv
package cpid_pkg;

  typedef enum logic {
    SRC_CARRIER     = 1'b0,
    SRC_RELOAD_EDGE = 1'b1
  } cpid_src_e;

  // Steady period length: a zero reload behaves as one.
  function automatic logic [31:0] eff_period(input logic [31:0] n);
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

  // First period after arming: one event short, never below one.
  function automatic logic [31:0] first_period_len(input logic [31:0] n);
    logic [31:0] e;
    e = eff_period(n);
    return (e > 32'd1) ? (e - 32'd1) : 32'd1;
  endfunction

endpackage

// File: rtl/cpid_edge_detect.sv
module cpid_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise_evt,
  output logic fall_evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign rise_evt = sig_in & ~prev_q;
  assign fall_evt = ~sig_in & prev_q;
endmodule

// File: rtl/cpid_src_select.sv
module cpid_src_select
  import cpid_pkg::*;
(
  input  logic mode_en,
  input  logic ext_mode,
  input  logic src_sel,
  input  logic edge_pol,
  input  logic carrier_uf,
  input  logic rise_evt,
  input  logic fall_evt,
  output logic cnt_event
);
  cpid_src_e src;
  logic      edge_evt;

  always_comb begin
    src = SRC_CARRIER;
    if (ext_mode && src_sel) src = SRC_RELOAD_EDGE;
  end

  assign edge_evt = edge_pol ? fall_evt : rise_evt;

  always_comb begin
    cnt_event = 1'b0;
    if (mode_en) begin
      case (src)
        SRC_RELOAD_EDGE: cnt_event = edge_evt;
        default:         cnt_event = carrier_uf;
      endcase
    end
  end
endmodule

// File: rtl/cpid_decim_counter.sv
module cpid_decim_counter
  import cpid_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             evt,
  input  logic [CNT_W-1:0] period,
  output logic             irq,
  output logic             first_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             period_hit
);
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    if (first_q) target = CNT_W'(first_period_len(32'(period)));
    else         target = CNT_W'(eff_period(32'(period)));
  end

  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign period_hit = evt && (cnt_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      irq     <= 1'b0;
    end else if (rearm) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      irq     <= 1'b0;
    end else if (period_hit) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      irq     <= 1'b1;
    end else begin
      if (evt) cnt_q <= cnt_inc;
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/carrier_irq_decimator.sv
module carrier_irq_decimator #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic             ext_mode,
  input  logic             src_sel,
  input  logic             edge_pol,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_data,
  input  logic             carrier_uf,
  input  logic             reload_ctl,
  output logic             irq
);
  logic [CNT_W-1:0] reload_q;
  logic             rise_evt;
  logic             fall_evt;
  logic             cnt_event;
  logic             rearm;
  logic             first_q;
  logic [CNT_W-1:0] cnt_q;
  logic             period_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= reload_data;
  end

  assign rearm = reload_wr | ~mode_en;

  cpid_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (reload_ctl),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cpid_src_select u_sel (
    .mode_en    (mode_en),
    .ext_mode   (ext_mode),
    .src_sel    (src_sel),
    .edge_pol   (edge_pol),
    .carrier_uf (carrier_uf),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .cnt_event  (cnt_event)
  );

  cpid_decim_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rearm      (rearm),
    .evt        (cnt_event),
    .period     (reload_q),
    .irq        (irq),
    .first_q    (first_q),
    .cnt_q      (cnt_q),
    .period_hit (period_hit)
  );
endmodule

// File: rtl/carrier_irq_decimator_chk.sv
module carrier_irq_decimator_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_en,
  input logic             ext_mode,
  input logic             src_sel,
  input logic             reload_wr,
  input logic             carrier_uf,
  input logic             reload_ctl,
  input logic             cnt_event,
  input logic             period_hit,
  input logic             first_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq
);
  // R1
  basic_mode_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && !ext_mode) |-> (cnt_event == carrier_uf));

  // R3
  edge_src_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && ext_mode && src_sel && cnt_event) |-> (reload_ctl != $past(reload_ctl)));

  // R7
  irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt_event && !reload_wr && mode_en));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!irq && first_q && cnt_q == '0));

  // R9
  rearm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (!irq && first_q && cnt_q == '0));

  // R5
  steady_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && mode_en && !reload_wr) |=> (!first_q && irq));
endmodule

bind carrier_irq_decimator carrier_irq_decimator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_en    (mode_en),
  .ext_mode   (ext_mode),
  .src_sel    (src_sel),
  .reload_wr  (reload_wr),
  .carrier_uf (carrier_uf),
  .reload_ctl (reload_ctl),
  .cnt_event  (cnt_event),
  .period_hit (period_hit),
  .first_q    (first_q),
  .cnt_q      (cnt_q),
  .irq        (irq)
);

// File: tb/tb_carrier_irq_decimator.sv
module tb_carrier_irq_decimator;
  localparam int CNT_W   = 8;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 9;

  // {n[7:0], ext, sel, pol, events[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'd3, 1'b0, 1'b1, 1'b1, 8'd8},   // R1 basic, select bits ignored
    {8'd4, 1'b0, 1'b0, 1'b0, 8'd3},   // R4 exactly first period
    {8'd4, 1'b0, 1'b0, 1'b0, 8'd2},   // R4 one short
    {8'd5, 1'b1, 1'b0, 1'b1, 8'd14},  // R2 carrier in extended mode
    {8'd3, 1'b1, 1'b1, 1'b0, 8'd8},   // R3 rising edges
    {8'd3, 1'b1, 1'b1, 1'b1, 8'd5},   // R3 falling edges
    {8'd0, 1'b0, 1'b0, 1'b0, 8'd6},   // R6 zero reload
    {8'd1, 1'b1, 1'b1, 1'b0, 8'd4},   // R6 reload one
    {8'd2, 1'b0, 1'b0, 1'b0, 8'd9}    // R5 steady periods
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_en = 1'b0;
  logic             ext_mode = 1'b0;
  logic             src_sel = 1'b0;
  logic             edge_pol = 1'b0;
  logic             reload_wr = 1'b0;
  logic [CNT_W-1:0] reload_data = '0;
  logic             carrier_uf = 1'b0;
  logic             reload_ctl = 1'b0;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  int irq_seen = 0;

  always #(CLK_PER/2) clk = ~clk;

  carrier_irq_decimator #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .ext_mode(ext_mode),
    .src_sel(src_sel), .edge_pol(edge_pol), .reload_wr(reload_wr),
    .reload_data(reload_data), .carrier_uf(carrier_uf),
    .reload_ctl(reload_ctl), .irq(irq)
  );

  always @(posedge clk) if (irq) irq_seen <= irq_seen + 1;

  function automatic int expect_irqs(int n, int ev);
    int per;
    int first;
    per   = (n < 1) ? 1 : n;
    first = (per > 1) ? per - 1 : 1;
    if (ev < first) return 0;
    return 1 + (ev - first) / per;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic write_reload(input int n);
    reload_wr = 1'b1; reload_data = CNT_W'(n);
    idle(1);
    reload_wr = 1'b0;
  endtask

  task automatic uf_pulse();
    carrier_uf = 1'b1; idle(1); carrier_uf = 1'b0; idle(1);
  endtask

  task automatic ctl_pulse();
    reload_ctl = 1'b1; idle(2); reload_ctl = 1'b0; idle(2);
  endtask

  // One counting event on the selected source, then a distractor on the other.
  task automatic one_event(input logic edge_src);
    if (edge_src) begin ctl_pulse(); uf_pulse(); end
    else          begin uf_pulse(); ctl_pulse(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 irq during reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R10 irq after reset", int'(irq), 0);

    // R10: stored reload 0 behaves as 1, first period one event
    mode_en = 1'b1;
    idle(1);
    irq_seen = 0;
    uf_pulse(); idle(2);
    chk("R10 reset reload acts as one", irq_seen, 1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      int  n;
      int  ev;
      logic use_edge;
      n        = int'(VEC[i][18:11]);
      ext_mode = VEC[i][10];
      src_sel  = VEC[i][9];
      edge_pol = VEC[i][8];
      ev       = int'(VEC[i][7:0]);
      use_edge = ext_mode & src_sel;
      reload_ctl = 1'b0;
      idle(2);
      write_reload(n);
      irq_seen = 0;
      for (int e = 0; e < ev; e++) one_event(use_edge);
      idle(3);
      chk($sformatf("R1/R2/R3/R4/R5/R6 vector %0d irq count", i),
          irq_seen, expect_irqs(n, ev));
    end

    // R7: cycle-exact single pulse, n=3 basic mode
    ext_mode = 1'b0; src_sel = 1'b0; edge_pol = 1'b0;
    write_reload(3);
    uf_pulse();
    carrier_uf = 1'b1; idle(1); carrier_uf = 1'b0;
    chk("R7 irq in cycle after event", int'(irq), 1);
    idle(1);
    chk("R7 irq lasts one cycle", int'(irq), 0);

    // R8: disabled, events ignored and re-armed
    write_reload(4);
    irq_seen = 0;
    uf_pulse(); uf_pulse();
    mode_en = 1'b0;
    idle(1);
    for (int e = 0; e < 6; e++) uf_pulse();
    chk("R8 no irq while disabled", irq_seen, 0);
    mode_en = 1'b1;
    idle(1);
    uf_pulse(); uf_pulse(); idle(2);
    chk("R8 re-armed, two events short of first period", irq_seen, 0);
    uf_pulse(); idle(2);
    chk("R8 first period completes after re-arm", irq_seen, 1);

    // R9: write re-arms mid-period
    write_reload(4);
    irq_seen = 0;
    uf_pulse(); uf_pulse();
    write_reload(4);
    uf_pulse(); uf_pulse(); idle(2);
    chk("R9 partial count discarded by write", irq_seen, 0);
    uf_pulse(); idle(2);
    chk("R9 first period after write", irq_seen, 1);

    // R9: write in the same cycle as the completing event
    write_reload(3);
    irq_seen = 0;
    uf_pulse();
    carrier_uf = 1'b1; reload_wr = 1'b1; reload_data = CNT_W'(3);
    idle(1);
    carrier_uf = 1'b0; reload_wr = 1'b0;
    idle(2);
    chk("R9 write beats same-cycle event", irq_seen, 0);
    uf_pulse(); idle(1);
    chk("R9 count restarts at zero", irq_seen, 0);
    uf_pulse(); idle(2);
    chk("R9 irq after fresh first period", irq_seen, 1);

    // R3: wrong edge not counted (falling polarity, hold high)
    ext_mode = 1'b1; src_sel = 1'b1; edge_pol = 1'b1;
    reload_ctl = 1'b0;
    write_reload(2);
    irq_seen = 0;
    reload_ctl = 1'b1; idle(4);
    chk("R3 rising edge ignored under falling polarity", irq_seen, 0);
    reload_ctl = 1'b0; idle(3);
    chk("R3 falling edge counted", irq_seen, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule